// File: doc/BRIEF.md
# Multi-channel shadowed configuration register bank

This block is the software-facing register file of a streaming core that serves several channels at once. It is an AXI4-Lite slave. A general space holds settings that apply to every channel; a write there reaches the output on the next cycle. A per-channel space holds settings for one channel at a time and is reached indirectly. Software first writes a channel index into the select register at offset 0x00C. It then fills a single shared shadow set through the per-channel window (0x080 to 0x13C). Finally it fires the commit bit in the control word at offset 0x000. The commit copies the whole shadow set into the active set of the selected channel in one clock edge. No other channel is touched.

Each channel has an enable, bit 0 of the word at channel offset 0x100. Committing with that bit set brings the channel up with the shadow contents. Committing with it clear resets the channel: its whole active set goes to zero. Because of this, software writes the enable last when it configures a channel after reset. Reads of the per-channel window return the committed values of the selected channel, never the shadow.

The AXI4-Lite front end is a small state machine. Its states are ST_IDLE, ST_WRESP and ST_RRESP. Its transitions are:
- WR_ACCEPT (ST_IDLE to ST_WRESP), taken when address and data of a write are both valid.
- RD_ACCEPT (ST_IDLE to ST_RRESP), taken on a read address when no complete write is pending.
- B_DONE (ST_WRESP to ST_IDLE), taken on bready.
- R_DONE (ST_RRESP to ST_IDLE), taken on rready.

Top module: `chan_cfg_regbank`

## Requirements
- R1: A write is accepted only when write address and write data are valid together. Every accepted write gets exactly one response and every accepted read exactly one data beat, both with response code 00 (OKAY). bvalid stays high until bready. rvalid stays high with stable rdata until rready. bvalid and rvalid are never high together.
- R2: General registers occupy the word offsets 0x010 to 0x03C and are read and written directly. A write reaches gen_regs_o on the cycle after the handshake. Only the bytes whose wstrb bit is set change.
- R3: The channel select register at offset 0x00C holds the low 8 bits of the written data (wstrb bit 0 required) and reads back that value, zero-extended.
- R4: Writes to the per-channel window 0x080 to 0x13C land in the shadow set only. ch_params_o and ch_en_o do not change until a commit.
- R5: A write to offset 0x000 with wstrb bit 0 and wdata bit 1 set is a commit. If the select register holds an index below NUM_CH, every active word of that channel is loaded from the shadow set on the same edge, and the other channels keep their values.
- R6: Offset 0x000 always reads as zero, so the commit bit reads back as 0.
- R7: A read of the per-channel window returns the active (committed) word of the selected channel.
- R8: When the select register holds an index of NUM_CH or more, per-channel writes are ignored (the shadow keeps its old contents), per-channel reads return zero and a commit changes nothing.
- R9: ch_en_o[c] equals bit 0 of the active word at channel offset 0x100 of channel c.
- R10: A commit whose shadow enable (bit 0 of channel offset 0x100) is clear resets that channel: all of its active words become zero, whatever the other shadow words hold.
- R11: A write to an offset with no register is answered OKAY and changes no output. A read of such an offset returns zero.
- R12: When a complete write and a read address arrive in the same cycle, the write is served first, and the read then returns the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code (always 00) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code (always 00) |
| gen_regs_o | output | GEN_WORDS*DATA_W | General registers; word i (offset 0x010+4i) at bits [i*DATA_W +: DATA_W] |
| ch_params_o | output | NUM_CH*CH_WORDS*DATA_W | Active channel sets; channel c, word w (offset 0x080+4w) at bits [(c*CH_WORDS+w)*DATA_W +: DATA_W] |
| ch_en_o | output | NUM_CH | Per-channel enable |

## Verification
The bench builds the block with its default parameters: three channels, a 48-word channel window that covers 0x080 to 0x13C, twelve general words and an 8-bit select register. With three channels the select register can hold indices 3 to 255, all out of range, so the ignore rules are exercised with a real index (5). With the window ending at 0x13C, a word inside the window (0x0B0) and the enable word (0x100) are both reachable. The bench also exercises the reset of a committed channel, partial byte strobes and a write and read that arrive together.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRESP = 2'd1,
        ST_RRESP = 2'd2
    } axil_state_t;

    // Word offsets (byte offset / 4) that software and neighbours depend on.
    localparam int CTRL_WORD     = 0;   // control, commit strobe
    localparam int SEL_WORD      = 3;   // channel select
    localparam int COMMIT_BIT    = 1;   // commit bit position in control
    localparam int GEN_BASE_WORD = 4;   // first general register
    localparam int CH_BASE_WORD  = 32;  // first per-channel word
    localparam int EN_WORD       = 32;  // enable word inside the channel window

endpackage

// File: rtl/axil_slave_fsm.sv
module axil_slave_fsm
    import regbank_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8,
    localparam int WA_W   = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              wr_en,
    output logic [WA_W-1:0]   wr_word,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    output logic [WA_W-1:0]   rd_word,
    input  logic [DATA_W-1:0] rd_data
);

    axil_state_t state_q;
    logic        wr_both;
    logic        rd_en;
    logic        unused_addr_lsb;

    assign wr_both         = awvalid && wvalid;
    assign unused_addr_lsb = ^{awaddr[1:0], araddr[1:0]};

    // State register with named transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_both)      state_q <= ST_WRESP;   // WR_ACCEPT
                    else if (arvalid) state_q <= ST_RRESP;   // RD_ACCEPT
                end
                ST_WRESP: if (bready) state_q <= ST_IDLE;    // B_DONE
                ST_RRESP: if (rready) state_q <= ST_IDLE;    // R_DONE
                default:              state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs of the front end.
    always_comb begin
        awready = 1'b0;
        wready  = 1'b0;
        arready = 1'b0;
        bvalid  = 1'b0;
        rvalid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                awready = wr_both;
                wready  = wr_both;
                arready = arvalid && !wr_both;
            end
            ST_WRESP: bvalid = 1'b1;
            ST_RRESP: rvalid = 1'b1;
            default: ;
        endcase
    end

    assign bresp   = 2'b00;
    assign rresp   = 2'b00;
    assign wr_en   = awready;
    assign wr_word = awaddr[ADDR_W-1:2];
    assign wr_data = wdata;
    assign wr_strb = wstrb;
    assign rd_en   = arready;
    assign rd_word = araddr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_data;
    end

endmodule

// File: rtl/gen_reg_file.sv
module gen_reg_file
    import regbank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int GEN_WORDS = 12,
    parameter int WA_W      = 10,
    localparam int STRB_W   = DATA_W / 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WA_W-1:0]             wr_word,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [STRB_W-1:0]           wr_strb,
    input  logic [WA_W-1:0]             rd_word,
    output logic [DATA_W-1:0]           rd_data,
    output logic [GEN_WORDS*DATA_W-1:0] regs_o
);

    localparam logic [WA_W-1:0] GEN_LO = WA_W'(GEN_BASE_WORD);

    logic [GEN_WORDS-1:0][DATA_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < GEN_WORDS; i++) begin
                for (int b = 0; b < STRB_W; b++) begin
                    if (wr_word == GEN_LO + WA_W'(i) && wr_strb[b])
                        regs_q[i][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < GEN_WORDS; i++) begin
            if (rd_word == GEN_LO + WA_W'(i)) rd_data = regs_q[i];
        end
    end

    assign regs_o = regs_q;

endmodule

// File: rtl/chan_bank.sv
module chan_bank
    import regbank_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_CH   = 3,
    parameter int CH_WORDS = 48,
    parameter int SEL_W    = 8,
    parameter int WA_W     = 10,
    localparam int STRB_W  = DATA_W / 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [WA_W-1:0]                    wr_word,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic [STRB_W-1:0]                  wr_strb,
    input  logic [WA_W-1:0]                    rd_word,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [NUM_CH*CH_WORDS*DATA_W-1:0]  params_o,
    output logic [NUM_CH-1:0]                  en_o
);

    localparam logic [WA_W-1:0]  SEL_A   = WA_W'(SEL_WORD);
    localparam logic [WA_W-1:0]  CTRL_A  = WA_W'(CTRL_WORD);
    localparam logic [WA_W-1:0]  CH_LO   = WA_W'(CH_BASE_WORD);
    localparam logic [SEL_W-1:0] CH_LIM  = SEL_W'(NUM_CH);

    logic [SEL_W-1:0]                             sel_q;
    logic [CH_WORDS-1:0][DATA_W-1:0]              shadow_q;
    logic [NUM_CH-1:0][CH_WORDS-1:0][DATA_W-1:0]  act_q;
    logic                                         sel_ok;
    logic                                         commit;

    assign sel_ok = sel_q < CH_LIM;
    assign commit = wr_en && (wr_word == CTRL_A) && wr_strb[0] && wr_data[COMMIT_BIT];

    // Channel select register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_en && wr_word == SEL_A && wr_strb[0])
            sel_q <= wr_data[SEL_W-1:0];
    end

    // Shared shadow set, written only while the selection is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en && sel_ok) begin
            for (int w = 0; w < CH_WORDS; w++) begin
                for (int b = 0; b < STRB_W; b++) begin
                    if (wr_word == CH_LO + WA_W'(w) && wr_strb[b])
                        shadow_q[w][b*8 +: 8] <= wr_data[b*8 +: 8];
                end
            end
        end
    end

    // Active sets: whole channel loaded or cleared on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (commit && sel_ok) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (sel_q == SEL_W'(c)) begin
                    if (shadow_q[EN_WORD][0]) act_q[c] <= shadow_q;
                    else                      act_q[c] <= '0;
                end
            end
        end
    end

    // Readback: select register or committed words of the selected channel.
    always_comb begin
        rd_data = '0;
        if (rd_word == SEL_A) rd_data = DATA_W'(sel_q);
        for (int c = 0; c < NUM_CH; c++) begin
            for (int w = 0; w < CH_WORDS; w++) begin
                if (sel_q == SEL_W'(c) && rd_word == CH_LO + WA_W'(w))
                    rd_data = act_q[c][w];
            end
        end
    end

    assign params_o = act_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_en
        assign en_o[c] = act_q[c][EN_WORD][0];
    end

endmodule

// File: rtl/chan_cfg_regbank.sv
module chan_cfg_regbank
    import regbank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_CH    = 3,
    parameter int CH_WORDS  = 48,
    parameter int GEN_WORDS = 12,
    parameter int SEL_W     = 8,
    localparam int STRB_W   = DATA_W / 8,
    localparam int WA_W     = ADDR_W - 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              s_awvalid,
    output logic                              s_awready,
    input  logic [ADDR_W-1:0]                 s_awaddr,
    input  logic                              s_wvalid,
    output logic                              s_wready,
    input  logic [DATA_W-1:0]                 s_wdata,
    input  logic [STRB_W-1:0]                 s_wstrb,
    output logic                              s_bvalid,
    input  logic                              s_bready,
    output logic [1:0]                        s_bresp,
    input  logic                              s_arvalid,
    output logic                              s_arready,
    input  logic [ADDR_W-1:0]                 s_araddr,
    output logic                              s_rvalid,
    input  logic                              s_rready,
    output logic [DATA_W-1:0]                 s_rdata,
    output logic [1:0]                        s_rresp,
    output logic [GEN_WORDS*DATA_W-1:0]       gen_regs_o,
    output logic [NUM_CH*CH_WORDS*DATA_W-1:0] ch_params_o,
    output logic [NUM_CH-1:0]                 ch_en_o
);

    logic              wr_en;
    logic [WA_W-1:0]   wr_word;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;
    logic [WA_W-1:0]   rd_word;
    logic [DATA_W-1:0] gen_rd;
    logic [DATA_W-1:0] ch_rd;

    axil_slave_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .awaddr  (s_awaddr),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .bresp   (s_bresp),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .araddr  (s_araddr),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .rd_word (rd_word),
        .rd_data (gen_rd | ch_rd)
    );

    gen_reg_file #(.DATA_W(DATA_W), .GEN_WORDS(GEN_WORDS), .WA_W(WA_W)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .rd_word (rd_word),
        .rd_data (gen_rd),
        .regs_o  (gen_regs_o)
    );

    chan_bank #(
        .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_WORDS(CH_WORDS),
        .SEL_W(SEL_W), .WA_W(WA_W)
    ) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .wr_data  (wr_data),
        .wr_strb  (wr_strb),
        .rd_word  (rd_word),
        .rd_data  (ch_rd),
        .params_o (ch_params_o),
        .en_o     (ch_en_o)
    );

endmodule

// File: rtl/chan_cfg_regbank_chk.sv
module chan_cfg_regbank_chk #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_CH   = 3,
    parameter int CH_WORDS = 48
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              s_awvalid,
    input logic                              s_awready,
    input logic [ADDR_W-1:0]                 s_awaddr,
    input logic                              s_wvalid,
    input logic [DATA_W-1:0]                 s_wdata,
    input logic                              s_wstrb0,
    input logic                              s_bvalid,
    input logic                              s_bready,
    input logic [1:0]                        s_bresp,
    input logic                              s_arvalid,
    input logic                              s_arready,
    input logic [ADDR_W-1:0]                 s_araddr,
    input logic                              s_rvalid,
    input logic                              s_rready,
    input logic [DATA_W-1:0]                 s_rdata,
    input logic [1:0]                        s_rresp,
    input logic [NUM_CH*CH_WORDS*DATA_W-1:0] ch_params_o,
    input logic [NUM_CH-1:0]                 ch_en_o
);

    logic commit_hs;
    logic ctrl_rd_hs;
    logic unused_chk;

    assign commit_hs  = s_awvalid && s_awready && s_wvalid && s_wstrb0 && s_wdata[1]
                        && (s_awaddr[ADDR_W-1:2] == '0);
    assign ctrl_rd_hs = s_arvalid && s_arready && (s_araddr[ADDR_W-1:2] == '0);
    assign unused_chk = ^{s_awaddr[1:0], s_araddr[1:0], s_wdata[DATA_W-1:2], s_wdata[0]};

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid);                                   // R1
    AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));               // R1
    AST_RESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid || s_rvalid) |-> (s_bresp == 2'b00 && s_rresp == 2'b00));    // R1
    AST_NO_DUAL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_bvalid && s_rvalid));                                              // R1
    AST_PARAMS_NEED_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_params_o) |-> $past(commit_hs));                           // R4
    AST_EN_NEED_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_en_o) |-> $past(commit_hs));                               // R9
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ch_en_o ^ $past(ch_en_o)) <= 1);                            // R5
    AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd_hs |=> s_rdata == '0);                                         // R6

endmodule

bind chan_cfg_regbank chan_cfg_regbank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_WORDS(CH_WORDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_awvalid   (s_awvalid),
    .s_awready   (s_awready),
    .s_awaddr    (s_awaddr),
    .s_wvalid    (s_wvalid),
    .s_wdata     (s_wdata),
    .s_wstrb0    (s_wstrb[0]),
    .s_bvalid    (s_bvalid),
    .s_bready    (s_bready),
    .s_bresp     (s_bresp),
    .s_arvalid   (s_arvalid),
    .s_arready   (s_arready),
    .s_araddr    (s_araddr),
    .s_rvalid    (s_rvalid),
    .s_rready    (s_rready),
    .s_rdata     (s_rdata),
    .s_rresp     (s_rresp),
    .ch_params_o (ch_params_o),
    .ch_en_o     (ch_en_o)
);

// File: tb/tb_chan_cfg_regbank.sv
`timescale 1ns/1ps
module tb_chan_cfg_regbank;

    localparam int AW = 12, DW = 32, NCH = 3, CW = 48, GW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
    logic [AW-1:0] awaddr = '0, araddr = '0;
    logic [DW-1:0] wdata = '0;
    logic [3:0]    wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [DW-1:0] rdata;
    logic [GW*DW-1:0] gen_regs_o;
    logic [NCH*CW*DW-1:0] ch_params_o;
    logic [NCH-1:0] ch_en_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    chan_cfg_regbank dut (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
        .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
        .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
        .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
        .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
        .gen_regs_o(gen_regs_o), .ch_params_o(ch_params_o), .ch_en_o(ch_en_o)
    );

    function automatic logic [DW-1:0] chw(int c, int w);
        return ch_params_o[(c*CW+w)*DW +: DW];
    endfunction

    function automatic logic [DW-1:0] genw(int i);
        return gen_regs_o[i*DW +: DW];
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compares read beats and write responses as they appear.
    always @(negedge clk) begin
        if (rst_n && rvalid && rready) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected read beat", 32'h1, 32'h0);
            end else begin
                automatic logic [DW-1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, rdata, e);
                chk("R1 rresp", {30'd0, rresp}, 32'd0);
            end
        end
        if (rst_n && bvalid && bready) chk("R1 bresp", {30'd0, bresp}, 32'd0);
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] s);
        @(negedge clk);
        awvalid = 1; wvalid = 1; awaddr = a; wdata = d; wstrb = s;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        while (bvalid) @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        arvalid = 1; araddr = a;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        while (rvalid) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [NCH*CW*DW-1:0] snap_p;
        logic [GW*DW-1:0] snap_g;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 reset bvalid/rvalid", {30'd0, bvalid, rvalid}, 32'd0);
        chk("R9 reset ch_en_o", {29'd0, ch_en_o}, 32'd0);
        chk("R2 reset gen word0", genw(0), 32'd0);
        rd(12'h00C, 32'd0, "R3 reset select");

        // General space
        wr(12'h010, 32'hA5A5_1234, 4'hF);
        chk("R2 gen word0 direct", genw(0), 32'hA5A5_1234);
        rd(12'h010, 32'hA5A5_1234, "R2 gen readback");
        wr(12'h014, 32'hFFFF_FFFF, 4'b0011);
        chk("R2 byte strobes", genw(1), 32'h0000_FFFF);

        // Select channel 1, fill shadow
        wr(12'h00C, 32'h0000_0001, 4'h1);
        rd(12'h00C, 32'd1, "R3 select readback");
        wr(12'h080, 32'h1111_0001, 4'hF);
        wr(12'h0B0, 32'h0000_0020, 4'hF);
        wr(12'h100, 32'h0000_0001, 4'hF);
        chk("R4 params before commit", {31'd0, (ch_params_o == '0)}, 32'd1);
        chk("R4 enable before commit", {29'd0, ch_en_o}, 32'd0);
        rd(12'h080, 32'd0, "R7 active not shadow");

        // Commit channel 1
        wr(12'h000, 32'h0000_0002, 4'h1);
        chk("R9 enable after commit", {29'd0, ch_en_o}, 32'b010);
        chk("R5 ch1 word 0x080", chw(1, 0), 32'h1111_0001);
        chk("R5 ch1 word 0x0B0", chw(1, 12), 32'h0000_0020);
        chk("R5 ch0 untouched", chw(0, 0), 32'd0);
        chk("R5 ch2 untouched", chw(2, 12), 32'd0);
        rd(12'h080, 32'h1111_0001, "R7 active readback ch1");
        rd(12'h000, 32'd0, "R6 control reads zero");

        // Channel reset by commit with enable clear
        wr(12'h00C, 32'd0, 4'h1);
        rd(12'h080, 32'd0, "R7 readback follows select");
        wr(12'h100, 32'd0, 4'hF);
        wr(12'h084, 32'h0000_DEAD, 4'hF);
        wr(12'h000, 32'h2, 4'h1);
        chk("R10 ch0 stays zero", chw(0, 1), 32'd0);
        chk("R10 enables ch0 commit", {29'd0, ch_en_o}, 32'b010);
        wr(12'h00C, 32'd1, 4'h1);
        wr(12'h000, 32'h2, 4'h1);
        chk("R10 ch1 cleared word", chw(1, 0), 32'd0);
        chk("R10 ch1 enable cleared", {29'd0, ch_en_o}, 32'd0);

        // Out-of-range select
        wr(12'h00C, 32'd5, 4'h1);
        rd(12'h00C, 32'd5, "R3 select holds 5");
        wr(12'h080, 32'h0000_0077, 4'hF);
        wr(12'h100, 32'h1, 4'hF);
        wr(12'h000, 32'h2, 4'h1);
        chk("R8 commit ignored", {31'd0, (ch_params_o == '0)}, 32'd1);
        rd(12'h080, 32'd0, "R8 read zero");
        wr(12'h00C, 32'd2, 4'h1);
        wr(12'h100, 32'h1, 4'hF);
        wr(12'h000, 32'h2, 4'h1);
        chk("R8 shadow kept old word", chw(2, 0), 32'h1111_0001);
        chk("R9 ch2 enable", {29'd0, ch_en_o}, 32'b100);

        // Unmapped space
        snap_p = ch_params_o; snap_g = gen_regs_o;
        wr(12'h040, 32'hFFFF_FFFF, 4'hF);
        wr(12'h200, 32'hFFFF_FFFF, 4'hF);
        wr(12'h008, 32'hFFFF_FFFF, 4'hF);
        chk("R11 params unchanged", {31'd0, (ch_params_o == snap_p)}, 32'd1);
        chk("R11 gen unchanged", {31'd0, (gen_regs_o == snap_g)}, 32'd1);
        rd(12'h040, 32'd0, "R11 unmapped read");

        // Write and read together
        exp_q.push_back(32'hCAFE_F00D); tag_q.push_back("R12 write before read");
        @(negedge clk);
        awvalid = 1; wvalid = 1; awaddr = 12'h018; wdata = 32'hCAFE_F00D; wstrb = 4'hF;
        arvalid = 1; araddr = 12'h018;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        while (rvalid || bvalid) @(negedge clk);

        // Response holds under back-pressure
        bready = 0;
        @(negedge clk);
        awvalid = 1; wvalid = 1; awaddr = 12'h01C; wdata = 32'h5; wstrb = 4'hF;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        repeat (3) begin
            chk("R1 bvalid held", {31'd0, bvalid}, 32'd1);
            @(negedge clk);
        end
        bready = 1;
        @(negedge clk);
        chk("R1 bvalid drops", {31'd0, bvalid}, 32'd0);

        rready = 0;
        exp_q.push_back(32'h5); tag_q.push_back("R1 held read data");
        @(negedge clk);
        arvalid = 1; araddr = 12'h01C;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        repeat (3) begin
            chk("R1 rvalid held", {31'd0, rvalid}, 32'd1);
            chk("R1 rdata stable", rdata, 32'h5);
            @(negedge clk);
        end
        rready = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 rvalid drops", {31'd0, rvalid}, 32'd0);
        chk("R1 scoreboard drained", exp_q.size(), 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule